// File: doc/BRIEF.md
# Masked SIMD Lane Array

This block is an eight-lane vector execution unit. Each cycle it can accept one decoded operation, and that operation goes to every lane at once. Each lane holds its own 32-bit register and combines it with its own slice of the operand bus. An execution mask, one bit per lane, decides which lanes write back. A lane whose bit is clear leaves its register untouched.

Divergent control flow is handled by running both sides of a condition one after the other. On a branch-open strobe, every lane tests its own register (strictly greater than zero, signed), and the results become the condition mask. Operations issued until the else strobe run under that mask. Operations issued after the else strobe run under its complement. The close strobe brings back the full mask, so all eight lanes run again.

A registered count of the lanes that did useful work on each issued operation is provided for throughput monitoring. Control strobes that arrive out of order are flagged and do not change the mask.

Top module: `simd_mask_unit`

## Requirements
- R1: With `issue` high, the 3-bit `opcode` is applied in every enabled lane i to that lane's register r and operand slice `operand[32*i +: 32]`, and the result is written at the clock edge. The codes are: 0 sets r to the operand, 1 adds the operand, 2 subtracts the operand, 3 ANDs, 4 ORs, 5 XORs, 6 shifts r left by the operand (an amount of 32 or more gives zero), and 7 leaves r unchanged.
- R2: On an accepted `br_begin`, lane i's condition bit is 1 when its register, read as signed, is greater than zero. The register value used is the one held before that edge, even when an operation issues in the same cycle. From the next cycle, `lane_mask` equals these condition bits.
- R3: A lane whose `lane_mask` bit is 0 keeps its register value across an issued operation.
- R4: An accepted `br_else` (only while on the then-path) makes `lane_mask` the bitwise inverse of the condition bits from the next cycle.
- R5: An accepted `br_end` (on either path) sets `lane_mask` to all ones from the next cycle. Outside a conditional region, `lane_mask` is always all ones.
- R6: `useful_cnt` shows, one cycle after an issue, the number of set bits in `lane_mask` during that issue. It shows 0 one cycle after a cycle with no issue.
- R7: An issue while `lane_mask` is all zeros changes no register and yields a count of 0.
- R8: A `br_end` or `br_else` outside a conditional region, or a `br_else` already on the else-path, pulses `seq_err` high for one cycle one cycle later. The mask is left unchanged, so outside a region it stays all ones.
- R9: A `br_begin` inside a conditional region is rejected the same way. It pulses `seq_err` and leaves the region and mask unchanged.
- R10: While `rst_n` is low, all lane registers are 0, `lane_mask` is all ones, `useful_cnt` is 0, `seq_err` is 0, and any open region is closed.
- R11: Two or more of `br_begin`, `br_else` and `br_end` in the same cycle are rejected together. This pulses `seq_err` and changes no control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An operation is presented this cycle |
| opcode | input | 3 | Operation broadcast to all lanes |
| br_begin | input | 1 | Open a conditional region; lanes sample their condition |
| br_else | input | 1 | Switch to the else-path (inverted mask) |
| br_end | input | 1 | Close the region; restore the full mask |
| operand | input | 256 | Per-lane operand, lane i in bits 32*i+31:32*i |
| result | output | 256 | Per-lane register contents, same packing |
| lane_mask | output | 8 | Active execution mask, bit i for lane i |
| useful_cnt | output | 4 | Lanes that committed on the previous cycle's issue |
| seq_err | output | 1 | One-cycle pulse for a rejected control strobe |

## Verification
The stimulus is built around a condition split where lanes holding zero or a negative value must fall out of the mask. A design that tested greater-or-equal, or compared without sign, would enable the wrong lanes on both paths.

Several corner cases are covered. One is a condition that is false in every lane, where a design that did not honour an empty mask would corrupt registers or report nonzero work. Another is a single surviving lane, the one-in-eight worst case, where an off-by-one in the population count would show. A third is an operation issued in the same cycle as the branch-open strobe, which exposes a design that samples the condition after write-back.

Stray, nested and simultaneous control strobes are also driven. A design that accepted them would leave the mask partial or flip paths, and this shows at `lane_mask` and `seq_err`. The bench also applies a reset in the middle of a region, which catches a mask that survives reset.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [2:0] {
    OP_MOV = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5,
    OP_SHL = 3'd6,
    OP_NOP = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    RG_IDLE = 2'd0,
    RG_THEN = 2'd1,
    RG_ELSE = 2'd2
  } region_e;

endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  op_e          op,
  input  logic [W-1:0] operand,
  output logic [W-1:0] value,
  output logic         cond
);

  logic [W-1:0] value_q;
  logic [W-1:0] value_d;
  logic [W-1:0] alu_out;

  // broadcast operation applied to this lane's register
  always_comb begin
    unique case (op)
      OP_MOV:  alu_out = operand;
      OP_ADD:  alu_out = value_q + operand;
      OP_SUB:  alu_out = value_q - operand;
      OP_AND:  alu_out = value_q & operand;
      OP_OR:   alu_out = value_q | operand;
      OP_XOR:  alu_out = value_q ^ operand;
      OP_SHL:  alu_out = value_q << operand;
      default: alu_out = value_q;
    endcase
  end

  // write enable: a masked lane holds its value
  always_comb begin
    value_d = value_q;
    if (commit) value_d = alu_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value_q <= '0;
    else        value_q <= value_d;
  end

  assign value = value_q;
  assign cond  = ($signed(value_q) > $signed({W{1'b0}}));

endmodule

// File: rtl/simd_popcnt.sv
module simd_popcnt #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CW'(bits[i]);
    end
  end

endmodule

// File: rtl/simd_mask_ctrl.sv
module simd_mask_ctrl
  import simd_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_begin,
  input  logic             br_else,
  input  logic             br_end,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] active,
  output region_e          region,
  output logic             seq_err
);

  region_e          region_q, region_d;
  logic [LANES-1:0] cond_q, cond_d;
  logic             err_q, err_d;
  logic             any_ctl, multi_ctl;
  logic             ok_begin, ok_else, ok_end;

  assign any_ctl   = br_begin | br_else | br_end;
  assign multi_ctl = (br_begin & br_else) | (br_begin & br_end) | (br_else & br_end);

  assign ok_begin = br_begin & ~multi_ctl & (region_q == RG_IDLE);
  assign ok_else  = br_else  & ~multi_ctl & (region_q == RG_THEN);
  assign ok_end   = br_end   & ~multi_ctl & (region_q != RG_IDLE);

  always_comb begin
    region_d = region_q;
    cond_d   = cond_q;
    err_d    = any_ctl & ~(ok_begin | ok_else | ok_end);
    if (ok_begin) begin
      region_d = RG_THEN;
      cond_d   = cond;
    end else if (ok_else) begin
      region_d = RG_ELSE;
    end else if (ok_end) begin
      region_d = RG_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region_q <= RG_IDLE;
      cond_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      region_q <= region_d;
      cond_q   <= cond_d;
      err_q    <= err_d;
    end
  end

  always_comb begin
    unique case (region_q)
      RG_THEN: active = cond_q;
      RG_ELSE: active = ~cond_q;
      default: active = '1;
    endcase
  end

  assign region  = region_q;
  assign seq_err = err_q;

endmodule

// File: rtl/simd_mask_unit.sv
module simd_mask_unit
  import simd_pkg::*;
#(
  parameter int LANES = 8,
  parameter int W     = 32,
  localparam int CW   = $clog2(LANES + 1),
  localparam int BW   = LANES * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [2:0]    opcode,
  input  logic          br_begin,
  input  logic          br_else,
  input  logic          br_end,
  input  logic [BW-1:0] operand,
  output logic [BW-1:0] result,
  output logic [LANES-1:0] lane_mask,
  output logic [CW-1:0] useful_cnt,
  output logic          seq_err
);

  op_e              op;
  region_e          region;
  logic [LANES-1:0] cond;
  logic [LANES-1:0] active;
  logic [CW-1:0]    pop;
  logic [CW-1:0]    cnt_q, cnt_d;

  assign op = op_e'(opcode);

  simd_mask_ctrl #(.LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .br_begin (br_begin),
    .br_else  (br_else),
    .br_end   (br_end),
    .cond     (cond),
    .active   (active),
    .region   (region),
    .seq_err  (seq_err)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    simd_lane #(.W(W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (issue & active[g]),
      .op      (op),
      .operand (operand[g*W +: W]),
      .value   (result[g*W +: W]),
      .cond    (cond[g])
    );
  end

  simd_popcnt #(.N(LANES), .CW(CW)) u_pop (
    .bits  (active),
    .count (pop)
  );

  always_comb begin
    cnt_d = '0;
    if (issue) cnt_d = pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign useful_cnt = cnt_q;
  assign lane_mask  = active;

endmodule

// File: rtl/simd_mask_chk.sv
module simd_mask_chk
  import simd_pkg::*;
#(
  parameter int LANES = 8,
  parameter int W     = 32,
  localparam int CW   = $clog2(LANES + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 issue,
  input logic                 br_begin,
  input logic                 br_else,
  input logic                 br_end,
  input logic [LANES*W-1:0]   result,
  input logic [LANES-1:0]     lane_mask,
  input logic [CW-1:0]        useful_cnt,
  input logic                 seq_err,
  input region_e              region
);

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> useful_cnt == '0);  // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    useful_cnt <= CW'(LANES));  // R6

  AST_EMPTY_NO_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && lane_mask == '0) |=> (useful_cnt == '0 && $stable(result)));  // R7

  AST_STRAY_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (br_end && !br_begin && !br_else && region == RG_IDLE) |=> (seq_err && lane_mask == '1));  // R8

  AST_ELSE_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (br_else && !br_begin && !br_end && region == RG_THEN) |=> lane_mask == ~$past(lane_mask));  // R4

  AST_END_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (br_end && !br_begin && !br_else && region != RG_IDLE) |=> (lane_mask == '1 && !seq_err));  // R5

  AST_IDLE_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    region == RG_IDLE |-> lane_mask == '1);  // R5

  AST_NESTED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (br_begin && region != RG_IDLE) |=> (seq_err && $stable(lane_mask)));  // R9

  AST_MULTI_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (br_begin && br_end) |=> (seq_err && $stable(lane_mask)));  // R11

  for (genvar g = 0; g < LANES; g++) begin : g_hold
    AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !lane_mask[g]) |=> $stable(result[g*W +: W]));  // R3
  end

endmodule

bind simd_mask_unit simd_mask_chk #(.LANES(LANES), .W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue      (issue),
  .br_begin   (br_begin),
  .br_else    (br_else),
  .br_end     (br_end),
  .result     (result),
  .lane_mask  (lane_mask),
  .useful_cnt (useful_cnt),
  .seq_err    (seq_err),
  .region     (region)
);

// File: tb/sim_simd_mask_unit.sv
module sim_simd_mask_unit;

  localparam int LANES = 8;
  localparam int W     = 32;
  localparam int NV    = 23;

  // vector: ctl{begin,else,end}[59:57] issue[56] op[55:53] base[52:21]
  //         step[20:13] exp_mask[12:5] exp_cnt[4:1] exp_err[0]
  localparam logic [59:0] VEC [NV] = '{
    {3'b000, 1'b1, 3'd0, 32'hFFFF_FFFD, 8'd1, 8'hFF, 4'd8, 1'b0}, // R1 MOV -3..4
    {3'b100, 1'b0, 3'd7, 32'h0,         8'd0, 8'hF0, 4'd0, 1'b0}, // R2 begin
    {3'b000, 1'b1, 3'd1, 32'd10,        8'd0, 8'hF0, 4'd4, 1'b0}, // R3 ADD then
    {3'b010, 1'b0, 3'd7, 32'h0,         8'd0, 8'h0F, 4'd0, 1'b0}, // R4 else
    {3'b000, 1'b1, 3'd0, 32'd100,       8'd1, 8'h0F, 4'd4, 1'b0}, // R4 MOV else
    {3'b001, 1'b0, 3'd7, 32'h0,         8'd0, 8'hFF, 4'd0, 1'b0}, // R5 end
    {3'b000, 1'b1, 3'd5, 32'hFFFF_FFFF, 8'd0, 8'hFF, 4'd8, 1'b0}, // R5 XOR full
    {3'b100, 1'b0, 3'd7, 32'h0,         8'd0, 8'h00, 4'd0, 1'b0}, // R7 all false
    {3'b000, 1'b1, 3'd1, 32'd5,         8'd0, 8'h00, 4'd0, 1'b0}, // R7 empty issue
    {3'b010, 1'b0, 3'd7, 32'h0,         8'd0, 8'hFF, 4'd0, 1'b0}, // R4 else full
    {3'b000, 1'b1, 3'd2, 32'd1,         8'd1, 8'hFF, 4'd8, 1'b0}, // R1 SUB
    {3'b001, 1'b0, 3'd7, 32'h0,         8'd0, 8'hFF, 4'd0, 1'b0}, // R5 end
    {3'b000, 1'b1, 3'd0, 32'hFFFF_FFFA, 8'd1, 8'hFF, 4'd8, 1'b0}, // R1 MOV -6..1
    {3'b100, 1'b0, 3'd7, 32'h0,         8'd0, 8'h80, 4'd0, 1'b0}, // R2 one lane
    {3'b000, 1'b1, 3'd6, 32'd3,         8'd0, 8'h80, 4'd1, 1'b0}, // R6 SHL worst
    {3'b010, 1'b0, 3'd7, 32'h0,         8'd0, 8'h7F, 4'd0, 1'b0}, // R4 else
    {3'b000, 1'b1, 3'd4, 32'd7,         8'd0, 8'h7F, 4'd7, 1'b0}, // R6 OR seven
    {3'b001, 1'b0, 3'd7, 32'h0,         8'd0, 8'hFF, 4'd0, 1'b0}, // R5 end
    {3'b001, 1'b0, 3'd7, 32'h0,         8'd0, 8'hFF, 4'd0, 1'b1}, // R8 stray end
    {3'b000, 1'b1, 3'd3, 32'h0000_00F0, 8'd1, 8'hFF, 4'd8, 1'b0}, // R1 AND
    {3'b010, 1'b0, 3'd7, 32'h0,         8'd0, 8'hFF, 4'd0, 1'b1}, // R8 stray else
    {3'b101, 1'b0, 3'd7, 32'h0,         8'd0, 8'hFF, 4'd0, 1'b1}, // R11 multi
    {3'b000, 1'b1, 3'd7, 32'h1234,      8'd1, 8'hFF, 4'd8, 1'b0}  // R1 NOP
  };

  logic                 clk;
  logic                 rst_n;
  logic                 issue;
  logic [2:0]           opcode;
  logic                 br_begin, br_else, br_end;
  logic [LANES*W-1:0]   operand;
  logic [LANES*W-1:0]   result;
  logic [LANES-1:0]     lane_mask;
  logic [3:0]           useful_cnt;
  logic                 seq_err;

  int          n_chk;
  int          n_bad;
  bit          done;
  logic [31:0] mdl [LANES];
  logic [7:0]  mdl_mask;

  simd_mask_unit u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .opcode     (opcode),
    .br_begin   (br_begin),
    .br_else    (br_else),
    .br_end     (br_end),
    .operand    (operand),
    .result     (result),
    .lane_mask  (lane_mask),
    .useful_cnt (useful_cnt),
    .seq_err    (seq_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_op(input logic [2:0] op, input logic [31:0] r, input logic [31:0] x);
    case (op)
      3'd0: return x;
      3'd1: return r + x;
      3'd2: return r - x;
      3'd3: return r & x;
      3'd4: return r | x;
      3'd5: return r ^ x;
      3'd6: return (x >= 32) ? 32'h0 : (r << x);
      default: return r;
    endcase
  endfunction

  // drive one cycle, update the model with the pre-edge mask, sample after the edge
  task automatic step(input logic [2:0] ctl, input logic iss, input logic [2:0] op,
                      input logic [31:0] base, input logic [7:0] stp, input logic [7:0] nmask);
    br_begin = ctl[2];
    br_else  = ctl[1];
    br_end   = ctl[0];
    issue    = iss;
    opcode   = op;
    for (int i = 0; i < LANES; i++) operand[i*W +: W] = base + 32'(i) * 32'(stp);
    @(negedge clk);
    if (iss) begin
      for (int i = 0; i < LANES; i++)
        if (mdl_mask[i]) mdl[i] = ref_op(op, mdl[i], operand[i*W +: W]);
    end
    mdl_mask = nmask;
  endtask

  task automatic check_lanes(input string tag);
    for (int i = 0; i < LANES; i++)
      check(result[i*W +: W] == mdl[i], tag, 64'(result[i*W +: W]), 64'(mdl[i]));
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; issue = 1'b0; opcode = 3'd7;
    br_begin = 1'b0; br_else = 1'b0; br_end = 1'b0; operand = '0;
    for (int i = 0; i < LANES; i++) mdl[i] = 32'h0;
    mdl_mask = 8'hFF;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(lane_mask == 8'hFF, "R10 mask in reset", 64'(lane_mask), 64'hFF);
    check(useful_cnt == 4'd0, "R10 count in reset", 64'(useful_cnt), 64'h0);
    check(seq_err == 1'b0, "R10 error in reset", 64'(seq_err), 64'h0);
    check(result == '0, "R10 registers in reset", 64'(result[63:0]), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][59:57], VEC[v][56], VEC[v][55:53], VEC[v][52:21], VEC[v][20:13], VEC[v][12:5]);
      check(lane_mask == VEC[v][12:5], $sformatf("R2/R4/R5 mask vec %0d", v), 64'(lane_mask), 64'(VEC[v][12:5]));
      check(useful_cnt == VEC[v][4:1], $sformatf("R6/R7 count vec %0d", v), 64'(useful_cnt), 64'(VEC[v][4:1]));
      check(seq_err == VEC[v][0], $sformatf("R8/R11 error vec %0d", v), 64'(seq_err), 64'(VEC[v][0]));
      check_lanes($sformatf("R1/R3 lanes vec %0d", v));
    end

    // R2: begin and issue together; condition uses pre-update values
    step(3'b000, 1'b1, 3'd0, 32'hFFFF_FFFF, 8'd1, 8'hFF);  // lanes -1..6
    step(3'b100, 1'b1, 3'd0, 32'h0, 8'd0, 8'hFC);
    check(lane_mask == 8'hFC, "R2 same-cycle condition", 64'(lane_mask), 64'hFC);
    check(useful_cnt == 4'd8, "R2 same-cycle issue full", 64'(useful_cnt), 64'h8);
    check_lanes("R2 same-cycle lanes");

    // R9: nested begin rejected, mask kept
    step(3'b100, 1'b0, 3'd7, 32'h0, 8'd0, 8'hFC);
    check(seq_err == 1'b1, "R9 nested begin flag", 64'(seq_err), 64'h1);
    check(lane_mask == 8'hFC, "R9 nested begin mask", 64'(lane_mask), 64'hFC);
    step(3'b010, 1'b0, 3'd7, 32'h0, 8'd0, 8'h03);
    // R8: second else rejected, mask kept
    step(3'b010, 1'b0, 3'd7, 32'h0, 8'd0, 8'h03);
    check(seq_err == 1'b1, "R8 double else flag", 64'(seq_err), 64'h1);
    check(lane_mask == 8'h03, "R8 double else mask", 64'(lane_mask), 64'h03);
    step(3'b000, 1'b0, 3'd7, 32'h0, 8'd0, 8'h03);
    check(seq_err == 1'b0, "R8 error is a pulse", 64'(seq_err), 64'h0);

    // R10: reset inside a region
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < LANES; i++) mdl[i] = 32'h0;
    mdl_mask = 8'hFF;
    check(lane_mask == 8'hFF, "R10 reset closes region", 64'(lane_mask), 64'hFF);
    check_lanes("R10 reset clears lanes");
    rst_n = 1'b1;
    @(negedge clk);
    step(3'b000, 1'b1, 3'd1, 32'd2, 8'd3, 8'hFF);
    check(useful_cnt == 4'd8, "R5 full width after reset", 64'(useful_cnt), 64'h8);
    check_lanes("R1 add after reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule